// File: doc/BRIEF.md
# Character Display Host Bus Port

This block is the processor-facing port of a character display controller. A host drives a register-select line, a read/write line, an enable strobe and a bidirectional 8-bit data bus. The port turns each completed transfer into a handoff to the instruction executor. A finished instruction byte goes out with a one-cycle valid pulse. A finished data byte goes out the same way. On reads, the port drives either a status byte or the contents of its data register back onto the bus.

The bus can run 8 bits wide or 4 bits wide, and the host can change the width at run time with a function-set instruction. In the narrow mode, only the upper four data lines carry information, and each byte takes two transfers with the upper nibble first. The data register works as a prefetch buffer. It asks the executor for a RAM fetch after any address-set instruction and after every completed host data read, and it loads whatever the executor returns.

Top module: `lcd_host_port`

## Requirements
- R1: After reset, the port is in 8-bit mode with the nibble phase on the upper half, the bus is released, and no handoff pulse is pending.
- R2: A transfer with regSel=0 and readNotWrite=0 is captured when enStrobe falls. It produces a single-cycle instrValid pulse, with the byte on instrByte.
- R3: A transfer with regSel=1 and readNotWrite=0 produces a single-cycle dataWrValid pulse, with the byte on dataWrByte. The same byte is also placed in the data register, so a later data read returns it.
- R4: While enStrobe is high with regSel=0 and readNotWrite=1, the bus carries busyIn on bit 7 and addrCntIn on bits 6:0.
- R5: While enStrobe is high with regSel=1 and readNotWrite=1, the bus carries the data register. Each completed data read raises fetchReq for one cycle, and a later fetchValid loads fetchData into the data register.
- R6: An instruction byte with bit 7 set (display address set) or with bits 7:6 = 01 (glyph address set) raises fetchReq. Any other instruction, and any data write, does not.
- R7: An instruction whose bits 7:5 are 001 sets the bus width from bit 4: 1 selects 8 bits and 0 selects 4 bits.
- R8: In 4-bit mode, a write takes two transfers on lines 7:4, upper nibble first. No handoff pulse occurs after the first transfer.
- R9: In 4-bit mode, a read presents the upper nibble of the status or data byte on lines 7:4 during the first transfer and the lower nibble during the second. A data read counts as complete only after the second transfer.
- R10: The port drives the bus only while readNotWrite=1 and enStrobe=1. At all other times, the lines are high impedance.
- R11: Nothing is committed while enStrobe stays high, however long that lasts. Only the falling edge completes a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| enStrobe | input | 1 | Host enable strobe, asynchronous to clk |
| regSel | input | 1 | 0 selects instruction/status, 1 selects data register |
| readNotWrite | input | 1 | 1 for a host read, 0 for a host write |
| dataBus | inout | 8 | Tri-state host data bus |
| busyIn | input | 1 | Busy status from the executor |
| addrCntIn | input | 7 | Address counter from the executor |
| instrValid | output | 1 | One-cycle pulse: instrByte is a new instruction |
| instrByte | output | 8 | Completed instruction byte |
| dataWrValid | output | 1 | One-cycle pulse: dataWrByte is new write data |
| dataWrByte | output | 8 | Completed data byte for RAM |
| fetchReq | output | 1 | Pulse asking the executor for the next RAM byte |
| fetchValid | input | 1 | Executor returns a fetched RAM byte |
| fetchData | input | 8 | Fetched RAM byte |

## Verification
The bench goes after the nibble ordering in both directions. A port that swapped the halves, or that committed after the first nibble, would hand off wrong bytes and show status digits in the wrong order. It switches widths in both directions by instruction and checks that the very next transfer is treated correctly. A missed mode change would split or merge bytes. It also checks the prefetch path: data read after a write, after an address set and after a previous read. A port that failed to fetch, or fetched on the wrong instructions, would return stale bytes or produce extra fetchReq pulses. Finally, it holds the strobe high for a long time and checks the bus enable during writes, so a port that committed on the rising edge or drove the bus during a write is caught.

// File: rtl/lcd_host_pkg.sv
package lcd_host_pkg;
  localparam int DATA_W = 8;
  localparam int NIB_W  = DATA_W / 2;
  localparam int ADDR_W = DATA_W - 1;

  // Strobes and mode state passed from control to datapath.
  typedef struct packed {
    logic latchHigh;    // 4-bit mode: store upper nibble of a write
    logic commitInstr;  // instruction byte complete
    logic commitData;   // data write byte complete
    logic readDone;     // data read complete
    logic nibPhase;     // 0: next transfer is upper nibble
    logic wideMode;     // 1: 8-bit bus
  } hostStrobe_t;
endpackage

// File: rtl/lcd_host_ctrl.sv
module lcd_host_ctrl
  import lcd_host_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enStrobe,
  input  logic              regSel,
  input  logic              readNotWrite,
  input  logic [DATA_W-1:0] fullByte,
  output hostStrobe_t       strobes,
  output logic              fetchReq
);
  localparam int TOP = SYNC_STAGES;

  logic [TOP:0] syncQ;
  logic         fallEvt;
  logic         wideMode, nibPhase;
  logic         completes, isFuncSet, isAddrSet, wideNext, wideChange;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[TOP-1:0], enStrobe};
  end

  assign fallEvt   = syncQ[TOP] & ~syncQ[TOP-1];
  assign completes = fallEvt & (wideMode | nibPhase);

  assign strobes.latchHigh   = fallEvt & ~wideMode & ~nibPhase & ~readNotWrite;
  assign strobes.commitInstr = completes & ~regSel & ~readNotWrite;
  assign strobes.commitData  = completes &  regSel & ~readNotWrite;
  assign strobes.readDone    = completes &  regSel &  readNotWrite;
  assign strobes.nibPhase    = nibPhase;
  assign strobes.wideMode    = wideMode;

  assign isFuncSet  = strobes.commitInstr && fullByte[DATA_W-1 -: 3] == 3'b001;
  assign isAddrSet  = fullByte[DATA_W-1] || fullByte[DATA_W-1 -: 2] == 2'b01;
  assign wideNext   = isFuncSet ? fullByte[DATA_W-4] : wideMode;
  assign wideChange = wideNext != wideMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wideMode <= 1'b1;
      nibPhase <= 1'b0;
      fetchReq <= 1'b0;
    end else begin
      wideMode <= wideNext;
      if (wideChange)                nibPhase <= 1'b0;
      else if (fallEvt && !wideMode) nibPhase <= ~nibPhase;
      fetchReq <= (strobes.commitInstr && isAddrSet) || strobes.readDone;
    end
  end

  // R8: at most one kind of completion per transfer
  a_r8_single_commit: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.latchHigh, strobes.commitInstr, strobes.commitData, strobes.readDone}));

  // R7: a width change leaves the phase on the upper nibble
  a_r7_phase_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (wideMode != $past(wideMode)) |-> !nibPhase);

  // R6: display address set always requests a prefetch
  a_r6_addr_fetch: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.commitInstr && fullByte[DATA_W-1]) |=> fetchReq);
endmodule

// File: rtl/lcd_host_dpath.sv
module lcd_host_dpath
  import lcd_host_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  hostStrobe_t       strobes,
  input  logic              regSel,
  input  logic [DATA_W-1:0] busIn,
  input  logic              busyIn,
  input  logic [ADDR_W-1:0] addrCntIn,
  input  logic              fetchValid,
  input  logic [DATA_W-1:0] fetchData,
  output logic [DATA_W-1:0] fullByte,
  output logic [DATA_W-1:0] busOut,
  output logic              instrValid,
  output logic [DATA_W-1:0] instrByte,
  output logic              dataWrValid,
  output logic [DATA_W-1:0] dataWrByte
);
  logic [NIB_W-1:0]  hiNib;
  logic [DATA_W-1:0] dataReg, readSrc;

  assign fullByte = strobes.wideMode ? busIn : {hiNib, busIn[DATA_W-1 -: NIB_W]};
  assign readSrc  = regSel ? dataReg : {busyIn, addrCntIn};

  always_comb begin
    if (strobes.wideMode)      busOut = readSrc;
    else if (strobes.nibPhase) busOut = {readSrc[NIB_W-1:0], {NIB_W{1'b0}}};
    else                       busOut = {readSrc[DATA_W-1 -: NIB_W], {NIB_W{1'b0}}};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiNib       <= '0;
      dataReg     <= '0;
      instrValid  <= 1'b0;
      instrByte   <= '0;
      dataWrValid <= 1'b0;
      dataWrByte  <= '0;
    end else begin
      if (strobes.latchHigh) hiNib <= busIn[DATA_W-1 -: NIB_W];
      instrValid  <= strobes.commitInstr;
      dataWrValid <= strobes.commitData;
      if (strobes.commitInstr) instrByte  <= fullByte;
      if (strobes.commitData)  dataWrByte <= fullByte;
      if (strobes.commitData)  dataReg    <= fullByte;
      else if (fetchValid)     dataReg    <= fetchData;
    end
  end

  // R5: a returned fetch lands in the data register
  a_r5_prefetch_load: assert property (@(posedge clk) disable iff (!rstN)
    (fetchValid && !strobes.commitData) |=> dataReg == $past(fetchData));

  // R2: instruction handoff is a single-cycle pulse
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    instrValid |=> !instrValid);

  // R3: data handoff is a single-cycle pulse
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    dataWrValid |=> !dataWrValid);
endmodule

// File: rtl/lcd_host_port.sv
module lcd_host_port
  import lcd_host_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        enStrobe,
  input  logic        regSel,
  input  logic        readNotWrite,
  inout  wire  [7:0]  dataBus,
  input  logic        busyIn,
  input  logic [6:0]  addrCntIn,
  output logic        instrValid,
  output logic [7:0]  instrByte,
  output logic        dataWrValid,
  output logic [7:0]  dataWrByte,
  output logic        fetchReq,
  input  logic        fetchValid,
  input  logic [7:0]  fetchData
);
  hostStrobe_t       strobes;
  logic [DATA_W-1:0] fullByte, busOut;
  logic              dataOe;

  // R10: drive only during a host read with the strobe high
  assign dataOe  = readNotWrite & enStrobe;
  assign dataBus = dataOe ? busOut : 'z;

  lcd_host_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .enStrobe(enStrobe), .regSel(regSel),
    .readNotWrite(readNotWrite), .fullByte(fullByte),
    .strobes(strobes), .fetchReq(fetchReq)
  );

  lcd_host_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .regSel(regSel),
    .busIn(dataBus), .busyIn(busyIn), .addrCntIn(addrCntIn),
    .fetchValid(fetchValid), .fetchData(fetchData),
    .fullByte(fullByte), .busOut(busOut),
    .instrValid(instrValid), .instrByte(instrByte),
    .dataWrValid(dataWrValid), .dataWrByte(dataWrByte)
  );
endmodule

// File: tb/lcd_host_port_bench.sv
`timescale 1ns/1ps
module lcd_host_port_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enStrobe = 1'b0, regSel = 1'b0, readNotWrite = 1'b0;
  logic       hostDrive = 1'b0;
  logic [7:0] hostVal = '0;
  tri   [7:0] dataBus;
  logic       busyIn = 1'b0;
  logic [6:0] addrCntIn = '0;
  logic       instrValid, dataWrValid, fetchReq;
  logic [7:0] instrByte, dataWrByte;
  logic       fetchValid = 1'b0;
  logic [7:0] fetchData = '0;

  int nChecks = 0, nFail = 0;
  int instrCnt = 0, dataCnt = 0, fetchCnt = 0;
  logic [7:0] lastInstr = '0, lastData = '0;
  logic done = 1'b0;

  assign dataBus = hostDrive ? hostVal : 'z;
  always #5 clk = ~clk;

  lcd_host_port u_lcd_host_port (
    .clk(clk), .rstN(rstN), .enStrobe(enStrobe), .regSel(regSel),
    .readNotWrite(readNotWrite), .dataBus(dataBus), .busyIn(busyIn),
    .addrCntIn(addrCntIn), .instrValid(instrValid), .instrByte(instrByte),
    .dataWrValid(dataWrValid), .dataWrByte(dataWrByte), .fetchReq(fetchReq),
    .fetchValid(fetchValid), .fetchData(fetchData)
  );

  // Executor model: answers each fetch request one cycle later.
  always @(posedge clk) begin
    if (instrValid)  begin lastInstr <= instrByte;  instrCnt <= instrCnt + 1; end
    if (dataWrValid) begin lastData  <= dataWrByte; dataCnt  <= dataCnt + 1;  end
    fetchValid <= fetchReq;
    if (fetchReq) begin
      fetchData <= 8'hC0 + 8'(fetchCnt);
      fetchCnt  <= fetchCnt + 1;
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic hostWrite(input logic rs, input logic [7:0] val);
    @(negedge clk);
    regSel = rs; readNotWrite = 1'b0; hostVal = val; hostDrive = 1'b1;
    repeat (2) @(negedge clk);
    enStrobe = 1'b1;
    repeat (4) @(negedge clk);
    enStrobe = 1'b0;
    repeat (10) @(negedge clk);
    hostDrive = 1'b0;
  endtask

  task automatic hostRead(input logic rs, output logic [7:0] val, output logic oe);
    @(negedge clk);
    regSel = rs; readNotWrite = 1'b1; hostDrive = 1'b0;
    repeat (2) @(negedge clk);
    enStrobe = 1'b1;
    repeat (3) @(negedge clk);
    val = dataBus;
    oe  = (dataBus !== 8'bzzzzzzzz);
    enStrobe = 1'b0;
    repeat (10) @(negedge clk);
    readNotWrite = 1'b0;
  endtask

  task automatic nibWrite(input logic rs, input logic [7:0] val);
    hostWrite(rs, {val[7:4], 4'h0});
    hostWrite(rs, {val[3:0], 4'h0});
  endtask

  task automatic nibRead(input logic rs, output logic [7:0] val);
    logic [7:0] a, b;
    logic oe;
    hostRead(rs, a, oe);
    hostRead(rs, b, oe);
    val = {a[7:4], b[7:4]};
  endtask

  typedef struct packed { logic rs; logic [7:0] val; } vec_t;
  localparam vec_t VECS [6] = '{
    '{1'b0, 8'h01}, '{1'b1, 8'h41}, '{1'b0, 8'h0C},
    '{1'b1, 8'h7E}, '{1'b0, 8'h06}, '{1'b1, 8'h5A}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic oe;
    int ic, dc, fc;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    // R1: reset state
    check("R1 bus released", {7'd0, dataBus !== 8'bzzzzzzzz}, 8'd0);
    check("R1 no pulses", 8'(instrCnt + dataCnt + fetchCnt), 8'd0);

    // R2/R3/R6: table of 8-bit writes, none of them address sets
    foreach (VECS[i]) begin
      ic = instrCnt; dc = dataCnt; fc = fetchCnt;
      hostWrite(VECS[i].rs, VECS[i].val);
      if (!VECS[i].rs) begin
        check("R2 instr count", 8'(instrCnt - ic), 8'd1);
        check("R2 instr byte", lastInstr, VECS[i].val);
      end else begin
        check("R3 data count", 8'(dataCnt - dc), 8'd1);
        check("R3 data byte", lastData, VECS[i].val);
      end
      check("R6 no fetch", 8'(fetchCnt - fc), 8'd0);
    end
    check("R1 8-bit default", 8'(instrCnt), 8'd3);

    // R3/R5: read back the written byte, then the prefetched one
    fc = fetchCnt;
    hostRead(1'b1, rd, oe);
    check("R3 readback", rd, 8'h5A);
    check("R10 oe on read", {7'd0, oe}, 8'd1);
    check("R5 fetch after read", 8'(fetchCnt - fc), 8'd1);
    hostRead(1'b1, rd, oe);
    check("R5 prefetched", rd, 8'hC0);

    // R4: status read
    busyIn = 1'b1; addrCntIn = 7'h23;
    hostRead(1'b0, rd, oe);
    check("R4 status", rd, 8'hA3);
    busyIn = 1'b0;
    check("R10 released after", {7'd0, dataBus !== 8'bzzzzzzzz}, 8'd0);

    // R10: no drive during a write with strobe high
    @(negedge clk);
    regSel = 1'b0; readNotWrite = 1'b0; hostVal = 8'h08; hostDrive = 1'b1;
    repeat (2) @(negedge clk);
    enStrobe = 1'b1;
    // R11: long high strobe commits nothing
    ic = instrCnt;
    repeat (20) @(negedge clk);
    check("R10 no drive on write", dataBus, 8'h08);
    check("R11 no commit while high", 8'(instrCnt - ic), 8'd0);
    enStrobe = 1'b0;
    repeat (10) @(negedge clk);
    hostDrive = 1'b0;
    check("R11 commit on fall", lastInstr, 8'h08);

    // R6: display and glyph address sets fetch
    fc = fetchCnt;
    hostWrite(1'b0, 8'h90);
    check("R6 display addr fetch", 8'(fetchCnt - fc), 8'd1);
    hostRead(1'b1, rd, oe);
    check("R6 fetched value", rd, 8'hC2);
    fc = fetchCnt;
    hostWrite(1'b0, 8'h48);
    check("R6 glyph addr fetch", 8'(fetchCnt - fc), 8'd1);

    // R7: switch to 4-bit mode
    hostWrite(1'b0, 8'h28);
    check("R7 func set seen", lastInstr, 8'h28);

    // R8: 4-bit writes
    ic = instrCnt;
    hostWrite(1'b0, 8'h00);
    check("R8 no commit after upper", 8'(instrCnt - ic), 8'd0);
    hostWrite(1'b0, 8'hF0);
    check("R8 instr assembled", lastInstr, 8'h0F);
    nibWrite(1'b1, 8'hB7);
    check("R8 data assembled", lastData, 8'hB7);

    // R9: 4-bit reads
    addrCntIn = 7'h5C;
    nibRead(1'b0, rd);
    check("R9 status nibbles", rd, 8'h5C);
    fc = fetchCnt;
    nibRead(1'b1, rd);
    check("R9 data nibbles", rd, 8'hB7);
    check("R9 one fetch per byte", 8'(fetchCnt - fc), 8'd1);

    // R7: back to 8-bit, then a single-transfer write
    nibWrite(1'b0, 8'h30);
    check("R7 func set 4-bit", lastInstr, 8'h30);
    ic = instrCnt;
    hostWrite(1'b0, 8'h02);
    check("R7 8-bit again", lastInstr, 8'h02);
    check("R7 single transfer", 8'(instrCnt - ic), 8'd1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule